// File: doc/BRIEF.md
# Saturating Pulse-Train Position Counter

This block keeps the present position of a pulse-train output as a signed 32-bit count. Each emitted output pulse moves the count one step, up for the clockwise direction and down for the counter-clockwise direction. When the count reaches either end of the signed 32-bit range it stays there instead of wrapping around. A host can load an origin value at any time. When relative coordinates are selected, the count returns to zero each time a new output operation begins.

Host software does not read the live count. It reads a snapshot register that is presented as an upper 16-bit word and a lower 16-bit word. The snapshot is refreshed on a once-per-scan strobe, and also at once whenever a preset is executed. When operation begins, both the count and the snapshot are cleared.

Top module: `pulse_pos_counter`

## Requirements
- R1: A cycle with `pulse_stb`=1 and `dir_cw`=1, and no higher-priority command, raises the count by exactly one.
- R2: A cycle with `pulse_stb`=1 and `dir_cw`=0, and no higher-priority command, lowers the count by exactly one.
- R3: A clockwise pulse while the count is 0x7FFFFFFF leaves the count at 0x7FFFFFFF.
- R4: A counter-clockwise pulse while the count is 0x80000000 leaves the count at 0x80000000.
- R5: When `out_start`=1 and `rel_mode`=1, the count is cleared to zero, and any pulse in the same cycle is discarded. When `rel_mode`=0, `out_start` has no effect on the count.
- R6: Synchronous reset `rst`, and the operation-start strobe `run_start`, clear both the count and the snapshot to zero.
- R7: `pv_hi` carries bits 31:16 of the snapshot and `pv_lo` carries bits 15:0.
- R8: The snapshot changes only on a clock edge where `scan_stb`, `preset_load` or `run_start` is 1. At that edge it takes the value the count takes at the same edge. Otherwise it holds.
- R9: `preset_load`=1 loads `preset_val` into the count and the snapshot at the same edge. The command order, from highest priority, is: `run_start`, `preset_load`, relative `out_start`, then the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_stb | input | 1 | One output pulse emitted this cycle |
| dir_cw | input | 1 | 1 = clockwise (count up), 0 = counter-clockwise (count down) |
| out_start | input | 1 | An output operation begins this cycle |
| rel_mode | input | 1 | 1 = relative coordinates (origin undefined) |
| preset_load | input | 1 | Load `preset_val` as the new position |
| preset_val | input | 32 | Signed value to load |
| run_start | input | 1 | Operation start: clear count and snapshot |
| scan_stb | input | 1 | Per-scan refresh of the snapshot |
| pv_hi | output | 16 | Snapshot bits 31:16 |
| pv_lo | output | 16 | Snapshot bits 15:0 |

## Verification
The in-RTL assertions are evaluated on every cycle of the live count. They cover the single-step moves in both directions, holding at both limits, the relative-mode clear, the preset load, and the snapshot holding still when no strobe is present. The bench's scenarios are needed to show the parts that involve ordering: the full priority order among simultaneous commands, that `out_start` is ignored in absolute mode, and how the snapshot lags the live count until a scan strobe, as seen through `pv_hi` and `pv_lo`.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_STEP  = 2'd3
  } ppc_act_e;
endpackage

// File: rtl/ppc_step.sv
module ppc_step #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             up,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] POS_LIM = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] NEG_LIM = {1'b1, {(CNT_W-1){1'b0}}};

  always_comb begin
    if (up) nxt = (cur == POS_LIM) ? cur : cur + 1'b1;
    else    nxt = (cur == NEG_LIM) ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/ppc_core.sv
module ppc_core
  import ppc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_stb,
  input  logic             dir_cw,
  input  logic             out_start,
  input  logic             rel_mode,
  input  logic             preset_load,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             run_start,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [CNT_W-1:0] POS_LIM = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] NEG_LIM = {1'b1, {(CNT_W-1){1'b0}}};

  ppc_act_e         act;
  logic [CNT_W-1:0] stepped;

  ppc_step #(.CNT_W(CNT_W)) step_i (
    .cur (cnt_q),
    .up  (dir_cw),
    .nxt (stepped)
  );

  always_comb begin
    if (run_start)                  act = ACT_CLEAR;
    else if (preset_load)           act = ACT_LOAD;
    else if (out_start && rel_mode) act = ACT_CLEAR;
    else if (pulse_stb)             act = ACT_STEP;
    else                            act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR: cnt_d = '0;
      ACT_LOAD:  cnt_d = preset_val;
      ACT_STEP:  cnt_d = stepped;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  logic quiet;
  assign quiet = !run_start && !preset_load && !(out_start && rel_mode);

  // R1
  a_r1_cw_step: assert property (@(posedge clk) disable iff (rst)
    (quiet && pulse_stb && dir_cw && cnt_q != POS_LIM) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  a_r2_ccw_step: assert property (@(posedge clk) disable iff (rst)
    (quiet && pulse_stb && !dir_cw && cnt_q != NEG_LIM) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (quiet && pulse_stb && dir_cw && cnt_q == POS_LIM) |=> cnt_q == POS_LIM);
  // R4
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (quiet && pulse_stb && !dir_cw && cnt_q == NEG_LIM) |=> cnt_q == NEG_LIM);
  // R5
  a_r5_rel_clear: assert property (@(posedge clk) disable iff (rst)
    (!run_start && !preset_load && out_start && rel_mode) |=> cnt_q == '0);
  // R9
  a_r9_preset: assert property (@(posedge clk) disable iff (rst)
    (!run_start && preset_load) |=> cnt_q == $past(preset_val));
  // R6
  a_r6_run_clear: assert property (@(posedge clk) disable iff (rst)
    run_start |=> cnt_q == '0);
endmodule

// File: rtl/ppc_snap.sv
module ppc_snap #(
  parameter int CNT_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CNT_W-1:0]  src,
  output logic [WORD_W-1:0] word_hi,
  output logic [WORD_W-1:0] word_lo
);
  localparam int N_WORDS = CNT_W / WORD_W;

  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)       snap_q <= '0;
    else if (take) snap_q <= src;
  end

  logic [WORD_W-1:0] words [N_WORDS];
  for (genvar g = 0; g < N_WORDS; g++) begin : g_split
    assign words[g] = snap_q[g*WORD_W +: WORD_W];
  end
  assign word_lo = words[0];
  assign word_hi = words[N_WORDS-1];

  // R8
  a_r8_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(snap_q));
  // R8
  a_r8_snap_take: assert property (@(posedge clk) disable iff (rst)
    take |=> snap_q == $past(src));
endmodule

// File: rtl/pulse_pos_counter.sv
module pulse_pos_counter #(
  parameter int CNT_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_stb,
  input  logic              dir_cw,
  input  logic              out_start,
  input  logic              rel_mode,
  input  logic              preset_load,
  input  logic [CNT_W-1:0]  preset_val,
  input  logic              run_start,
  input  logic              scan_stb,
  output logic [WORD_W-1:0] pv_hi,
  output logic [WORD_W-1:0] pv_lo
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  ppc_core #(.CNT_W(CNT_W)) core_i (
    .clk         (clk),
    .rst         (rst),
    .pulse_stb   (pulse_stb),
    .dir_cw      (dir_cw),
    .out_start   (out_start),
    .rel_mode    (rel_mode),
    .preset_load (preset_load),
    .preset_val  (preset_val),
    .run_start   (run_start),
    .cnt_q       (cnt_q),
    .cnt_d       (cnt_d)
  );

  ppc_snap #(.CNT_W(CNT_W), .WORD_W(WORD_W)) snap_i (
    .clk     (clk),
    .rst     (rst),
    .take    (scan_stb || preset_load || run_start),
    .src     (cnt_d),
    .word_hi (pv_hi),
    .word_lo (pv_lo)
  );

  // R7: the two words together cover the whole count
  initial begin
    a_r7_word_split: assert (2 * WORD_W == CNT_W);
  end
endmodule

// File: tb/pulse_pos_counter_tb.sv
module pulse_pos_counter_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        pulse_stb = 0, dir_cw = 0, out_start = 0, rel_mode = 0;
  logic        preset_load = 0, run_start = 0, scan_stb = 0;
  logic [31:0] preset_val = '0;
  logic [15:0] pv_hi, pv_lo;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pulse_pos_counter dut_i (
    .clk(clk), .rst(rst), .pulse_stb(pulse_stb), .dir_cw(dir_cw),
    .out_start(out_start), .rel_mode(rel_mode), .preset_load(preset_load),
    .preset_val(preset_val), .run_start(run_start), .scan_stb(scan_stb),
    .pv_hi(pv_hi), .pv_lo(pv_lo)
  );

  typedef struct packed {
    logic        pul, cw, st, rel, pre, run, scn;
    logic [31:0] val;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,0,0,1, 32'h0,        32'h00000001}, // R1
    '{1,1,0,0,0,0,1, 32'h0,        32'h00000002}, // R1
    '{1,0,0,0,0,0,1, 32'h0,        32'h00000001}, // R2
    '{0,0,0,0,0,0,1, 32'h0,        32'h00000001}, // hold
    '{1,1,0,0,1,0,1, 32'h7FFFFFFE, 32'h7FFFFFFE}, // R9 preset beats pulse
    '{1,1,0,0,0,0,1, 32'h0,        32'h7FFFFFFF}, // R1
    '{1,1,0,0,0,0,1, 32'h0,        32'h7FFFFFFF}, // R3
    '{1,0,1,0,0,0,1, 32'h0,        32'h7FFFFFFE}, // R5 absolute start ignored
    '{1,1,1,1,0,0,1, 32'h0,        32'h00000000}, // R5 rel clear beats pulse
    '{0,0,0,0,1,0,1, 32'h80000001, 32'h80000001}, // R9
    '{1,0,0,0,0,0,1, 32'h0,        32'h80000000}, // R2
    '{1,0,0,0,0,0,1, 32'h0,        32'h80000000}, // R4
    '{1,1,1,1,1,0,1, 32'h12345678, 32'h12345678}, // R9 preset beats rel clear
    '{1,1,0,0,1,1,1, 32'h0BADF00D, 32'h00000000}  // R6 run_start beats preset
  };

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if ({pv_hi, pv_lo} !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, {pv_hi, pv_lo}, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    pulse_stb = v.pul; dir_cw = v.cw; out_start = v.st; rel_mode = v.rel;
    preset_load = v.pre; run_start = v.run; scan_stb = v.scn; preset_val = v.val;
    @(negedge clk);
    pulse_stb = 0; out_start = 0; preset_load = 0; run_start = 0; scan_stb = 0;
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R6 reset", 32'h0);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check($sformatf("vector %0d", i), VECS[i].exp);
    end
    // R7: separate word check
    drive('{0,0,0,0,1,0,0, 32'hABCD1234, 32'h0});
    checks++;
    if (pv_hi !== 16'hABCD || pv_lo !== 16'h1234) begin
      errors++;
      $display("FAIL R7: actual %h/%h expected abcd/1234", pv_hi, pv_lo);
    end
    // R8: pulses without scan strobe leave snapshot alone
    drive('{1,1,0,0,0,0,0, 32'h0, 32'h0});
    drive('{1,1,0,0,0,0,0, 32'h0, 32'h0});
    check("R8 hold", 32'hABCD1234);
    drive('{0,0,0,0,0,0,1, 32'h0, 32'h0});
    check("R8 refresh", 32'hABCD1236);
    // R6: run_start alone clears
    drive('{0,0,0,0,0,1,0, 32'h0, 32'h0});
    check("R6 run_start", 32'h0);
    // R6: reset clears after nonzero
    drive('{0,0,0,0,1,0,0, 32'h00000055, 32'h0});
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R6 reset again", 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule